// File: doc/BRIEF.md
# T1/E1 Transmit Line Encoder

This block is the transmit front end of a T1/E1 line interface. It takes system data that arrives with a transmit clock and turns it into a ternary line symbol. The symbol is driven on two outputs: a positive-pulse enable and a negative-pulse enable. Both are low for a space. All logic runs on a free-running master clock, which must be several times faster than the transmit clock. The transmit clock and the data pins pass through a two-flop synchronizer. The selected edge of the synchronized clock then produces one symbol strobe per bit.

Static configuration inputs choose the operating mode:
- T1 or E1 rate.
- Single-rail data, or a pair of rail pins.
- Plain AMI, or zero substitution (B8ZS for T1, HDB3 for E1).
- The sampling edge.
- The data polarity.

A hardware-strap input forces falling-edge sampling and active-high data. The same master clock measures the gap between transmit clock edges. When the gap is too long, the block raises a sticky loss flag and a maskable interrupt. Configuration is expected to change only while reset is held.

Top module: `txLineEncoder`

## Requirements
- R1: After reset both pulse outputs, `symValid`, `lossFlag` and `irq` are low. In single-rail mode the first 8 symbols (T1) or 4 symbols (E1) after reset are spaces.
- R2: Single-rail AMI mode is selected with `cfgAmi`=1. Each data 1 becomes a pulse and each data 0 becomes a space. Pulse polarity alternates, and the first pulse after reset is positive. Output lags input by 8 symbols in T1 (`cfgT1`=1) and by 4 symbols in E1 (`cfgT1`=0).
- R3: In single-rail T1 mode with `cfgAmi`=0, every run of eight zeros is sent as 000VB0VB. A V pulse has the same polarity as the pulse before it. A B pulse has the opposite polarity of the pulse before it.
- R4: In single-rail E1 mode with `cfgAmi`=0, every run of four zeros is sent as 000V or B00V. 000V is used when an odd number of B/mark pulses has been sent since the last V; otherwise B00V is used.
- R5: In dual-rail mode (`cfgDualRail`=1) the encoder is bypassed with no symbol delay. Rails (P,N)=(1,0) give a negative pulse, (0,1) give a positive pulse, and (0,0) or (1,1) give a space.
- R6: `cfgRiseEdge`=1 samples data on the rising transmit clock edge; 0 samples on the falling edge.
- R7: `cfgInvert`=1 treats all data pins as active low.
- R8: With `hwStrap`=1, falling-edge sampling and active-high data are used whatever `cfgRiseEdge` and `cfgInvert` say.
- R9: `lossFlag` sets when the transmit clock shows no edge for more than LOSS_LIMIT (default 70) master clock cycles. It stays set until `lossClear` is pulsed. While the clock is still missing, setting wins over clearing.
- R10: `irq` is high when `lossFlag` is set and `irqMask` is low.
- R11: `posPulse` and `negPulse` are never high together, and they change only in a cycle where `symValid` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mclk | input | 1 | Free-running master clock |
| rstN | input | 1 | Active-low synchronous reset |
| txClk | input | 1 | Transmit clock from the system side |
| txData | input | 1 | Single-rail data, or the P rail in dual-rail mode |
| txDataN | input | 1 | N rail in dual-rail mode |
| hwStrap | input | 1 | Forces falling edge and active-high data |
| cfgT1 | input | 1 | 1 = T1 rate, 0 = E1 rate |
| cfgDualRail | input | 1 | 1 = dual-rail input, encoder bypassed |
| cfgAmi | input | 1 | 1 = plain AMI, 0 = B8ZS/HDB3 substitution |
| cfgRiseEdge | input | 1 | 1 = sample on rising edge, 0 = falling |
| cfgInvert | input | 1 | 1 = data pins active low |
| irqMask | input | 1 | Masks the loss interrupt |
| lossClear | input | 1 | Clear strobe for the loss flag |
| posPulse | output | 1 | Positive line pulse enable |
| negPulse | output | 1 | Negative line pulse enable |
| symValid | output | 1 | One-cycle pulse when a new symbol is presented |
| lossFlag | output | 1 | Sticky loss-of-transmit-clock flag |
| irq | output | 1 | Maskable loss interrupt |

## Verification
The hardest situation to reach from the ports is an HDB3 substitution that must pick B00V instead of 000V. This depends on the pulse parity since the last violation, which includes marks still inside the delay window. The bench reaches both branches with data streams built to produce them: one mark then four zeros gives an odd count, and two marks after a violation give an even count, followed by back-to-back zero runs. Another hard case is clearing the loss flag while the clock is still stopped, where the set must win. The bench holds the transmit clock idle past the limit and then pulses the clear.

// File: rtl/txLinePkg.sv
package txLinePkg;
  localparam int T1_SUB_LEN = 8;
  localparam int E1_SUB_LEN = 4;

  typedef enum logic [2:0] {
    SYM_IDLE,
    SYM_ZERO,
    SYM_MARK,
    SYM_BIP,
    SYM_VIOL
  } symKind_e;

  typedef struct packed {
    logic sample;
    logic dataBit;
    logic railP;
    logic railN;
  } txStrobe_t;
endpackage

// File: rtl/txCtrl.sv
module txCtrl
  import txLinePkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int LOSS_LIMIT  = 70
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      txClk,
  input  logic      txData,
  input  logic      txDataN,
  input  logic      useRise,
  input  logic      invert,
  input  logic      lossClear,
  output txStrobe_t strobe,
  output logic      lossFlag
);
  localparam int CNT_W = $clog2(LOSS_LIMIT + 1);

  logic [SYNC_STAGES-1:0] clkSync, pSync, nSync;
  logic clkPrev;
  logic [CNT_W-1:0] idleCnt;
  logic clkNow, riseSeen, fallSeen, anyEdge, lossSet;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      clkSync <= '0;
      pSync   <= '0;
      nSync   <= '0;
      clkPrev <= 1'b0;
    end else begin
      clkSync <= {clkSync[SYNC_STAGES-2:0], txClk};
      pSync   <= {pSync[SYNC_STAGES-2:0], txData};
      nSync   <= {nSync[SYNC_STAGES-2:0], txDataN};
      clkPrev <= clkNow;
    end
  end

  assign clkNow   = clkSync[SYNC_STAGES-1];
  assign riseSeen = clkNow & ~clkPrev;
  assign fallSeen = ~clkNow & clkPrev;
  assign anyEdge  = riseSeen | fallSeen;

  always_comb begin
    strobe.sample  = useRise ? riseSeen : fallSeen;
    strobe.dataBit = pSync[SYNC_STAGES-1] ^ invert;
    strobe.railP   = pSync[SYNC_STAGES-1] ^ invert;
    strobe.railN   = nSync[SYNC_STAGES-1] ^ invert;
  end

  assign lossSet = !anyEdge && (idleCnt == CNT_W'(LOSS_LIMIT));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idleCnt  <= '0;
      lossFlag <= 1'b0;
    end else begin
      if (anyEdge) idleCnt <= '0;
      else if (idleCnt != CNT_W'(LOSS_LIMIT)) idleCnt <= idleCnt + 1'b1;
      if (lossSet) lossFlag <= 1'b1;
      else if (lossClear) lossFlag <= 1'b0;
    end
  end
endmodule

// File: rtl/txEncoder.sv
module txEncoder
  import txLinePkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  txStrobe_t strobe,
  input  logic      isT1,
  input  logic      dualRail,
  input  logic      amiOnly,
  output logic      posPulse,
  output logic      negPulse,
  output logic      symValid
);
  localparam int WIN   = T1_SUB_LEN;
  localparam int TAP_W = $clog2(WIN);

  symKind_e win [WIN];
  symKind_e nxt [WIN];
  symKind_e emit;
  logic [TAP_W-1:0] tapIdx;
  logic lastNeg, oddCnt;
  logic emitPulse, emitViol, emitPos, emitNeg, lastNegNext, oddNext, allZero;

  always_comb begin
    tapIdx = isT1 ? TAP_W'(T1_SUB_LEN - 1) : TAP_W'(E1_SUB_LEN - 1);
    emit   = win[tapIdx];
    emitPulse = (emit == SYM_MARK) || (emit == SYM_BIP);
    emitViol  = (emit == SYM_VIOL);
    emitPos   = (emitPulse && lastNeg) || (emitViol && !lastNeg);
    emitNeg   = (emitPulse && !lastNeg) || (emitViol && lastNeg);
    lastNegNext = emitPulse ? !lastNeg : lastNeg;
    oddNext     = emitViol ? 1'b0 : (emitPulse ? !oddCnt : oddCnt);

    nxt[0] = strobe.dataBit ? SYM_MARK : SYM_ZERO;
    for (int i = 1; i < WIN; i++) nxt[i] = win[i-1];

    allZero = 1'b1;
    for (int i = 0; i < WIN; i++) begin
      if ((i <= int'(tapIdx)) && (nxt[i] != SYM_ZERO)) allZero = 1'b0;
    end

    if (allZero && !amiOnly) begin
      if (isT1) begin
        nxt[4] = SYM_VIOL;
        nxt[3] = SYM_BIP;
        nxt[1] = SYM_VIOL;
        nxt[0] = SYM_BIP;
      end else begin
        nxt[0] = SYM_VIOL;
        if (!oddNext) nxt[3] = SYM_BIP;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < WIN; i++) win[i] <= SYM_IDLE;
      lastNeg  <= 1'b1;
      oddCnt   <= 1'b0;
      posPulse <= 1'b0;
      negPulse <= 1'b0;
      symValid <= 1'b0;
    end else begin
      symValid <= strobe.sample;
      if (strobe.sample) begin
        if (dualRail) begin
          posPulse <= strobe.railN & ~strobe.railP;
          negPulse <= strobe.railP & ~strobe.railN;
        end else begin
          for (int i = 0; i < WIN; i++) win[i] <= nxt[i];
          posPulse <= emitPos;
          negPulse <= emitNeg;
          lastNeg  <= lastNegNext;
          oddCnt   <= oddNext;
        end
      end
    end
  end
endmodule

// File: rtl/txLineEncoder.sv
module txLineEncoder
  import txLinePkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int LOSS_LIMIT  = 70
) (
  input  logic mclk,
  input  logic rstN,
  input  logic txClk,
  input  logic txData,
  input  logic txDataN,
  input  logic hwStrap,
  input  logic cfgT1,
  input  logic cfgDualRail,
  input  logic cfgAmi,
  input  logic cfgRiseEdge,
  input  logic cfgInvert,
  input  logic irqMask,
  input  logic lossClear,
  output logic posPulse,
  output logic negPulse,
  output logic symValid,
  output logic lossFlag,
  output logic irq
);
  txStrobe_t ctrlBus;
  logic effRise, effInvert;

  assign effRise   = hwStrap ? 1'b0 : cfgRiseEdge;
  assign effInvert = hwStrap ? 1'b0 : cfgInvert;

  txCtrl #(.SYNC_STAGES(SYNC_STAGES), .LOSS_LIMIT(LOSS_LIMIT)) u_ctrl (
    .clk(mclk), .rstN(rstN), .txClk(txClk), .txData(txData), .txDataN(txDataN),
    .useRise(effRise), .invert(effInvert), .lossClear(lossClear),
    .strobe(ctrlBus), .lossFlag(lossFlag)
  );

  txEncoder u_enc (
    .clk(mclk), .rstN(rstN), .strobe(ctrlBus), .isT1(cfgT1),
    .dualRail(cfgDualRail), .amiOnly(cfgAmi),
    .posPulse(posPulse), .negPulse(negPulse), .symValid(symValid)
  );

  assign irq = lossFlag & ~irqMask;
endmodule

// File: rtl/txLineEncoderChk.sv
module txLineEncoderChk
  import txLinePkg::*;
(
  input logic      clk,
  input logic      rstN,
  input logic      cfgDualRail,
  input logic      cfgAmi,
  input logic      posPulse,
  input logic      negPulse,
  input logic      symValid,
  input logic      lossFlag,
  input logic      lossClear,
  input logic      irqMask,
  input logic      irq,
  input txStrobe_t strobe
);
  logic chkLastNeg;

  always_ff @(posedge clk) begin
    if (!rstN) chkLastNeg <= 1'b1;
    else if (symValid && posPulse) chkLastNeg <= 1'b0;
    else if (symValid && negPulse) chkLastNeg <= 1'b1;
  end

  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(posPulse && negPulse)); // R11
  AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rstN)
    !symValid |-> ($stable(posPulse) && $stable(negPulse))); // R11
  AST_AMI_ALTERNATE: assert property (@(posedge clk) disable iff (!rstN)
    (symValid && cfgAmi && !cfgDualRail && (posPulse || negPulse)) |-> (posPulse == chkLastNeg)); // R2
  AST_DUAL_MAP: assert property (@(posedge clk) disable iff (!rstN)
    (symValid && cfgDualRail) |->
      ((posPulse == ($past(strobe.railN) && !$past(strobe.railP))) &&
       (negPulse == ($past(strobe.railP) && !$past(strobe.railN))))); // R5
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (lossFlag && !lossClear) |=> lossFlag); // R9
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    irqMask |-> !irq); // R10
endmodule

bind txLineEncoder txLineEncoderChk u_chk (
  .clk(mclk), .rstN(rstN), .cfgDualRail(cfgDualRail), .cfgAmi(cfgAmi),
  .posPulse(posPulse), .negPulse(negPulse), .symValid(symValid),
  .lossFlag(lossFlag), .lossClear(lossClear), .irqMask(irqMask), .irq(irq),
  .strobe(ctrlBus)
);

// File: tb/tb_txLineEncoder.sv
module tb_txLineEncoder;
  logic mclk = 1'b0;
  logic rstN = 1'b0;
  logic txClk = 1'b0, txData = 1'b0, txDataN = 1'b0;
  logic hwStrap = 1'b0, cfgT1 = 1'b0, cfgDualRail = 1'b0, cfgAmi = 1'b0;
  logic cfgRiseEdge = 1'b0, cfgInvert = 1'b0, irqMask = 1'b0, lossClear = 1'b0;
  logic posPulse, negPulse, symValid, lossFlag, irq;

  int errs = 0, total = 0, cycles = 0;
  int rxCount = 0;
  logic [1:0] rx [0:63];
  logic lg [0:63];
  logic rn [0:63];
  logic [1:0] expSym [0:63];
  logic [1:0] sym [0:127];
  int symCnt;
  logic mLastNeg, mOdd;

  always #4 mclk = ~mclk;

  txLineEncoder dut (.*);

  always @(negedge mclk) begin
    if (!rstN) rxCount <= 0;
    else if (symValid && rxCount < 64) begin
      rx[rxCount] <= {posPulse, negPulse};
      rxCount <= rxCount + 1;
    end
  end

  always @(posedge mclk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errs = errs + 1;
      total = total + 1;
      $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errs, total);
      $finish;
    end
  end

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(int k);
    repeat (k) @(negedge mclk);
  endtask

  task automatic doReset();
    rstN = 1'b0; txClk = 1'b0; txData = 1'b0; txDataN = 1'b0; lossClear = 1'b0;
    cyc(4);
    rstN = 1'b1;
    cyc(2);
  endtask

  task automatic sendBit(logic p, logic n);
    txData = p; txDataN = n;
    cyc(4); txClk = 1'b1;
    cyc(6); txClk = 1'b0;
    cyc(6);
  endtask

  task automatic sendSplit(logic ap, logic an, logic bp, logic bn);
    txData = ap; txDataN = an;
    cyc(4); txClk = 1'b1;
    cyc(5); txData = bp; txDataN = bn;
    cyc(5); txClk = 1'b0;
    cyc(6);
  endtask

  task automatic emitSym(int t);
    if (t == 0) sym[symCnt] = 2'b00;
    else if (t == 1) begin
      sym[symCnt] = mLastNeg ? 2'b10 : 2'b01;
      mLastNeg = !mLastNeg;
      mOdd = !mOdd;
    end else begin
      sym[symCnt] = mLastNeg ? 2'b01 : 2'b10;
      mOdd = 1'b0;
    end
    symCnt++;
  endtask

  task automatic buildExp(bit t1, bit ami, bit dual, int n);
    int len;
    int pat [8];
    int i;
    bit allz;
    len = t1 ? 8 : 4;
    if (dual) begin
      for (int k = 0; k < n; k++) expSym[k] = {!lg[k] && rn[k], lg[k] && !rn[k]};
      return;
    end
    mLastNeg = 1'b1; mOdd = 1'b0; symCnt = 0; i = 0;
    while (i < n) begin
      allz = (i + len <= n);
      if (allz) for (int j = 0; j < len; j++) if (lg[i+j]) allz = 0;
      if (!ami && allz) begin
        if (t1) pat = '{0, 0, 0, 2, 1, 0, 2, 1};
        else if (mOdd) pat = '{0, 0, 0, 2, 0, 0, 0, 0};
        else pat = '{1, 0, 0, 2, 0, 0, 0, 0};
        for (int j = 0; j < len; j++) emitSym(pat[j]);
        i += len;
      end else begin
        emitSym(lg[i] ? 1 : 0);
        i++;
      end
    end
    for (int k = 0; k < n; k++) expSym[k] = (k < len) ? 2'b00 : sym[k-len];
  endtask

  task automatic runStream(string req, bit t1, bit ami, bit dual, bit inv, int n);
    cfgT1 = t1; cfgAmi = ami; cfgDualRail = dual; cfgInvert = inv;
    cfgRiseEdge = 1'b0; hwStrap = 1'b0;
    doReset();
    for (int k = 0; k < n; k++) sendBit(lg[k] ^ inv, (dual ? rn[k] : 1'b0) ^ inv);
    cyc(6);
    buildExp(t1, ami, dual, n);
    chk({req, " symbol count"}, rxCount, n);
    for (int k = 0; k < n && k < rxCount; k++) chk(req, int'(rx[k]), int'(expSym[k]));
  endtask

  task automatic testReset();
    doReset();
    chk("R1 posPulse", posPulse, 0);
    chk("R1 negPulse", negPulse, 0);
    chk("R1 symValid", symValid, 0);
    chk("R1 lossFlag", lossFlag, 0);
    chk("R1 irq", irq, 0);
  endtask

  task automatic testAmi();
    logic [19:0] v;
    v = 20'b1101_0011_1011_0000_1001;
    for (int k = 0; k < 20; k++) lg[k] = v[19-k];
    runStream("R2 AMI T1", 1, 1, 0, 0, 20);
    runStream("R2 AMI E1", 0, 1, 0, 0, 20);
  endtask

  task automatic testB8zs();
    for (int k = 0; k < 40; k++) lg[k] = 1'b0;
    lg[0] = 1; lg[9] = 1; lg[10] = 1; lg[27] = 1;
    runStream("R3 B8ZS", 1, 0, 0, 0, 40);
  endtask

  task automatic testHdb3();
    for (int k = 0; k < 30; k++) lg[k] = 1'b0;
    lg[0] = 1; lg[5] = 1; lg[6] = 1; lg[15] = 1; lg[21] = 1;
    runStream("R4 HDB3", 0, 0, 0, 0, 30);
  endtask

  task automatic testDual();
    logic [7:0] pv, nv;
    pv = 8'b1010_0110; nv = 8'b0110_1010;
    for (int k = 0; k < 8; k++) begin lg[k] = pv[7-k]; rn[k] = nv[7-k]; end
    runStream("R5 dual rail", 1, 0, 1, 0, 8);
    runStream("R5 dual rail E1", 0, 1, 1, 0, 8);
  endtask

  task automatic splitCase(string req, bit strap, bit rise, bit inv, logic [1:0] exp);
    cfgDualRail = 1'b1; cfgT1 = 1'b0; cfgAmi = 1'b0;
    hwStrap = strap; cfgRiseEdge = rise; cfgInvert = inv;
    doReset();
    for (int k = 0; k < 3; k++) sendSplit(1'b0, 1'b1, 1'b1, 1'b0);
    cyc(6);
    chk({req, " count"}, rxCount, 3);
    for (int k = 0; k < 3 && k < rxCount; k++) chk(req, int'(rx[k]), int'(exp));
  endtask

  task automatic testEdges();
    splitCase("R6 rising edge", 0, 1, 0, 2'b10);
    splitCase("R6 falling edge", 0, 0, 0, 2'b01);
    splitCase("R8 strap forces falling", 1, 1, 0, 2'b01);
    splitCase("R8 strap ignores invert", 1, 0, 1, 2'b01);
  endtask

  task automatic testInvert();
    for (int k = 0; k < 4; k++) begin lg[k] = 1'b1; rn[k] = 1'b0; end
    runStream("R7 invert dual", 0, 0, 1, 1, 4);
    for (int k = 0; k < 12; k++) lg[k] = 1'b1;
    runStream("R7 invert AMI", 0, 1, 0, 1, 12);
  endtask

  task automatic testLoss();
    irqMask = 1'b0; hwStrap = 1'b0; cfgDualRail = 1'b0;
    doReset();
    cyc(58);
    chk("R9 no loss before limit", lossFlag, 0);
    cyc(50);
    chk("R9 loss set", lossFlag, 1);
    chk("R10 irq unmasked", irq, 1);
    irqMask = 1'b1;
    cyc(1);
    chk("R10 irq masked", irq, 0);
    chk("R10 flag kept under mask", lossFlag, 1);
    lossClear = 1'b1; cyc(1); lossClear = 1'b0; cyc(1);
    chk("R9 set wins over clear", lossFlag, 1);
    sendBit(1'b1, 1'b0);
    sendBit(1'b0, 1'b0);
    chk("R9 sticky after clock returns", lossFlag, 1);
    lossClear = 1'b1; cyc(1); lossClear = 1'b0; cyc(1);
    chk("R9 cleared", lossFlag, 0);
    sendBit(1'b1, 1'b0);
    sendBit(1'b1, 1'b0);
    chk("R9 stays clear with clock", lossFlag, 0);
    irqMask = 1'b0;
  endtask

  initial begin
    testReset();
    testAmi();
    testB8zs();
    testHdb3();
    testDual();
    testEdges();
    testInvert();
    testLoss();
    $display("Result: errors=%0d of %0d checks", errs, total);
    $finish;
  end
endmodule